// File: doc/BRIEF.md
# Interrupt Distributor with Per-Interrupt Lifecycle

This block collects up to 16 software-raised interrupts and 32 wired peripheral interrupts, keeps a lifecycle state for each, and offers a single processor interface the most urgent interrupt that is waiting. Software programs it through a plain register bus (write enable, word address, write data). Each interrupt has its own priority byte, an enable bit and, for wired sources, a choice of edge or level sensing. A global enable gates everything that is forwarded.

Every interrupt moves through four named states: `ST_IDLE` (inactive), `ST_PEND` (pending), `ST_ACT` (active) and `ST_ACTPEND` (active and pending). The transitions are: *raise* (IDLE to PEND on an edge, a software raise or a high level), *withdraw* (PEND to IDLE when a level input drops), *take* (PEND to ACT on acknowledge, or to ACTPEND if a new edge arrives in the same cycle), *re-raise* (ACT to ACTPEND on a new event), *finish* (ACT to IDLE on end of interrupt), *resume* (ACTPEND to PEND on end of interrupt) and *settle* (ACTPEND to ACT when a level input drops). The outputs are combinational from registered state, so the presented winner reflects the state after the last clock edge. The processor acknowledges the presented ID with an `ack_valid` pulse and signals completion with an `eoi_valid` pulse.

Top module: `irq_distributor`

## Requirements
- R1: After reset every interrupt is inactive, the global enable is off, and the outputs show `out_valid`=0, `out_id`=1023 (the spurious ID) and `out_prio`=8'hFF.
- R2: A wired source in edge mode that sees its input rise becomes pending and stays pending after the input falls, until it is acknowledged.
- R3: A wired source in level mode is pending only while its input is high; when the input drops before acknowledge it returns to inactive and is no longer presented.
- R4: Among enabled pending interrupts the one with the numerically smallest priority value is presented; equal priorities go to the smallest ID.
- R5: Acknowledging the presented ID moves it out of pending and stops presenting it; an acknowledge naming an interrupt that is not pending changes nothing.
- R6: End of interrupt returns an active interrupt to inactive, and an active-and-pending interrupt to pending so it is presented again.
- R7: A new edge on an active interrupt is recorded as active-and-pending, is not presented while active, and is not lost.
- R8: With the global enable (address 0x00, bit 0) off nothing is presented; with a per-interrupt enable off that interrupt is skipped. Pending state is kept while gated and shows again when re-enabled.
- R9: Software interrupts use IDs 0 to 15 and are raised by writing their ID in bits 3:0 to address 0x01; wired input k uses ID 32+k. Software interrupts always behave as edge events.
- R10: The settings of interrupt slot n (slot n = ID n for software interrupts, slot 16+k for wired input k) are written at address 0x40+n: priority in bits 7:0, enable in bit 8, edge mode in bit 9 (0 = level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| spi_in | input | 32 | Wired peripheral interrupt inputs, bit k is ID 32+k |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| ack_valid | input | 1 | Acknowledge pulse |
| ack_id | input | 10 | ID being acknowledged |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_id | input | 10 | ID being completed |
| out_valid | output | 1 | An enabled interrupt is pending |
| out_id | output | 10 | Presented ID, 1023 when none |
| out_prio | output | 8 | Priority of the presented ID, 8'hFF when none |

## Verification
Every stimulus (a register write, an input change, an acknowledge or an end of interrupt) is sampled at one rising edge, and its result is visible on the outputs right after that same edge, because the winner is chosen combinationally from the registered states and settings. The bench drives each stimulus on a falling edge, removes pulses on the next falling edge, and only then queues the expected output; the monitor compares at the following falling edge, one full cycle after the change, when the outputs are stable and no input drives them combinationally.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PEND    = 2'd1,
        ST_ACT     = 2'd2,
        ST_ACTPEND = 2'd3
    } irq_st_e;

    localparam int ID_W       = 10;
    localparam int SPURIOUS   = 1023;
    localparam int CTRL_ADDR  = 'h00;
    localparam int SGI_ADDR   = 'h01;
    localparam int CFG_BASE   = 'h40;
    localparam int CFG_EN_BIT = 8;
    localparam int CFG_ED_BIT = 9;
endpackage

// File: rtl/irqd_cell.sv
module irqd_cell
    import irqd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic edge_mode,
    input  logic sw_set,
    input  logic ack,
    input  logic eoi,
    output logic pend
);
    irq_st_e state_q, state_d;
    logic    src_q;
    logic    evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src;
        end
    end

    // edge mode: a new rise or a software raise; level mode: input high
    assign evt = edge_mode ? ((src & ~src_q) | sw_set) : (src | sw_set);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (evt) state_d = ST_PEND;
            ST_PEND: begin
                if (ack)
                    state_d = (edge_mode && evt) ? ST_ACTPEND : ST_ACT;
                else if (!edge_mode && !evt)
                    state_d = ST_IDLE;
            end
            ST_ACT: begin
                if (eoi)      state_d = evt ? ST_PEND : ST_IDLE;
                else if (evt) state_d = ST_ACTPEND;
            end
            ST_ACTPEND: begin
                if (eoi)                      state_d = ST_PEND;
                else if (!edge_mode && !evt)  state_d = ST_ACT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pend = (state_q == ST_PEND);
    end

    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && state_q == ST_PEND && !ack) |=> (state_q == ST_PEND));

    p_level_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && state_q == ST_PEND && !src && !sw_set && !ack) |=> (state_q == ST_IDLE));

    p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && ack) |=> (state_q == ST_ACT || state_q == ST_ACTPEND));

    p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTPEND && eoi) |=> (state_q == ST_PEND));

    p_keep_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && state_q == ST_ACT && !eoi && sw_set) |=> (state_q == ST_ACTPEND));
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
    parameter int N      = 48,
    parameter int PRIO_W = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]             cand,
    input  logic [N-1:0][PRIO_W-1:0] prio,
    output logic                     found,
    output logic [IDX_W-1:0]         win_idx,
    output logic [PRIO_W-1:0]        win_prio
);
    // ascending scan with strict compare: equal priority keeps the lower slot
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '1;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || prio[i] < win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int N_SGI    = 16,
    parameter int N_SPI    = 32,
    parameter int SPI_BASE = 32,
    parameter int PRIO_W   = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SPI-1:0]    spi_in,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                ack_valid,
    input  logic [ID_W-1:0]     ack_id,
    input  logic                eoi_valid,
    input  logic [ID_W-1:0]     eoi_id,
    output logic                out_valid,
    output logic [ID_W-1:0]     out_id,
    output logic [PRIO_W-1:0]   out_prio
);
    localparam int N     = N_SGI + N_SPI;
    localparam int IDX_W = $clog2(N);

    logic [N-1:0][PRIO_W-1:0] prio_q;
    logic [N-1:0]             en_q, edge_q, pend, cand, ack_vec, eoi_vec, sgi_set;
    logic                     gen_en_q;
    logic                     found;
    logic [IDX_W-1:0]         win_idx;
    logic [PRIO_W-1:0]        win_prio;
    int                       cfg_slot;

    function automatic int slot_of(input logic [ID_W-1:0] id);
        int v;
        v = int'(id);
        if (v < N_SGI)                                return v;
        else if (v >= SPI_BASE && v < SPI_BASE + N_SPI) return v - SPI_BASE + N_SGI;
        else                                          return -1;
    endfunction

    always_comb begin
        cfg_slot = int'(reg_addr) - CFG_BASE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_en_q <= 1'b0;
            prio_q   <= '0;
            en_q     <= '0;
            edge_q   <= '0;
        end else if (reg_we) begin
            if (int'(reg_addr) == CTRL_ADDR)
                gen_en_q <= reg_wdata[0];
            if (cfg_slot >= 0 && cfg_slot < N) begin
                prio_q[cfg_slot] <= reg_wdata[PRIO_W-1:0];
                en_q[cfg_slot]   <= reg_wdata[CFG_EN_BIT];
                edge_q[cfg_slot] <= reg_wdata[CFG_ED_BIT];
            end
        end
    end

    always_comb begin
        ack_vec = '0;
        eoi_vec = '0;
        sgi_set = '0;
        if (ack_valid && slot_of(ack_id) >= 0) ack_vec[slot_of(ack_id)] = 1'b1;
        if (eoi_valid && slot_of(eoi_id) >= 0) eoi_vec[slot_of(eoi_id)] = 1'b1;
        if (reg_we && int'(reg_addr) == SGI_ADDR && int'(reg_wdata[3:0]) < N_SGI)
            sgi_set[int'(reg_wdata[3:0])] = 1'b1;
    end

    for (genvar i = 0; i < N; i++) begin : g_slot
        if (i < N_SGI) begin : g_sgi
            irqd_cell u_cell (
                .clk(clk), .rst_n(rst_n), .src(1'b0), .edge_mode(1'b1),
                .sw_set(sgi_set[i]), .ack(ack_vec[i]), .eoi(eoi_vec[i]), .pend(pend[i])
            );
        end else begin : g_spi
            irqd_cell u_cell (
                .clk(clk), .rst_n(rst_n), .src(spi_in[i-N_SGI]), .edge_mode(edge_q[i]),
                .sw_set(1'b0), .ack(ack_vec[i]), .eoi(eoi_vec[i]), .pend(pend[i])
            );
        end
    end

    assign cand = pend & en_q & {N{gen_en_q}};

    irqd_pick #(.N(N), .PRIO_W(PRIO_W)) u_pick (
        .cand(cand), .prio(prio_q), .found(found),
        .win_idx(win_idx), .win_prio(win_prio)
    );

    always_comb begin
        out_valid = found;
        out_prio  = found ? win_prio : {PRIO_W{1'b1}};
        if (!found)
            out_id = ID_W'(SPURIOUS);
        else if (int'(win_idx) < N_SGI)
            out_id = ID_W'(win_idx);
        else
            out_id = ID_W'(int'(win_idx) - N_SGI + SPI_BASE);
    end

    p_global_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> gen_en_q);

    p_idle_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_id == ID_W'(SPURIOUS) && out_prio == {PRIO_W{1'b1}}));

    p_ack_removes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ack_valid && ack_id == out_id) |=> !(out_valid && out_id == $past(ack_id)));
endmodule

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] spi_in = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        ack_valid = 1'b0;
    logic [9:0]  ack_id = '0;
    logic        eoi_valid = 1'b0;
    logic [9:0]  eoi_id = '0;
    logic        out_valid;
    logic [9:0]  out_id;
    logic [7:0]  out_prio;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        logic       v;
        logic [9:0] id;
        logic [7:0] p;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    irq_distributor u_dut (
        .clk(clk), .rst_n(rst_n), .spi_in(spi_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ack_valid(ack_valid),
        .ack_id(ack_id), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
        .out_valid(out_valid), .out_id(out_id), .out_prio(out_prio)
    );

    // monitor: compares queued expectations on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (out_valid !== e.v || out_id !== e.id || out_prio !== e.p) begin
                    fails++;
                    $display("FAIL %s: got valid=%0b id=%0d prio=%0h, expected valid=%0b id=%0d prio=%0h",
                             e.tag, out_valid, out_id, out_prio, e.v, e.id, e.p);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog: got cycles=%0d, expected completion", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    task automatic expect_out(input logic v, input int id, input int p, input string tag);
        exp_t e;
        e.v = v; e.id = 10'(id); e.p = 8'(p); e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = 32'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse_src(input logic [31:0] m);
        spi_in = spi_in | m;
        @(negedge clk);
        spi_in = spi_in & ~m;
    endtask

    task automatic do_ack(input int id);
        ack_valid = 1'b1; ack_id = 10'(id);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic do_eoi(input int id);
        eoi_valid = 1'b1; eoi_id = 10'(id);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    localparam int EN = 1 << 8;
    localparam int ED = 1 << 9;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1'b0, 1023, 'hFF, "R1 reset idle");

        wr('h00, 1);
        wr('h40 + 16, ED | EN | 'h80);          // R10 slot of input 0
        expect_out(1'b0, 1023, 'hFF, "R10 config alone raises nothing");
        pulse_src(32'h1);
        expect_out(1'b1, 32, 'h80, "R2 R9 edge raises ID 32");
        repeat (3) @(negedge clk);
        expect_out(1'b1, 32, 'h80, "R2 held after input low");

        do_ack(40);
        expect_out(1'b1, 32, 'h80, "R5 ack of non-pending ignored");
        do_ack(32);
        expect_out(1'b0, 1023, 'hFF, "R5 ack removes");

        pulse_src(32'h1);
        expect_out(1'b0, 1023, 'hFF, "R7 edge while active not presented");
        do_eoi(32);
        expect_out(1'b1, 32, 'h80, "R6 R7 resume to pending");
        do_ack(32);
        do_eoi(32);
        expect_out(1'b0, 1023, 'hFF, "R6 finish to inactive");

        wr('h40 + 21, EN | 'h40);               // input 5, level
        spi_in[5] = 1'b1;
        @(negedge clk);
        expect_out(1'b1, 37, 'h40, "R3 level high pending");
        spi_in[5] = 1'b0;
        @(negedge clk);
        expect_out(1'b0, 1023, 'hFF, "R3 level drop withdraws");

        wr('h40 + 17, ED | EN | 'h20);
        wr('h40 + 18, ED | EN | 'h20);
        wr('h40 + 19, ED | EN | 'h10);
        pulse_src(32'h6);
        expect_out(1'b1, 33, 'h20, "R4 tie goes to lower ID");
        pulse_src(32'h8);
        expect_out(1'b1, 35, 'h10, "R4 lower value wins");
        wr('h40 + 3, EN | 'h20);
        wr('h01, 3);
        expect_out(1'b1, 35, 'h10, "R9 software raise below current");
        do_ack(35);
        expect_out(1'b1, 3, 'h20, "R4 R9 software ID 3 wins tie");

        wr('h00, 0);
        expect_out(1'b0, 1023, 'hFF, "R8 global disable");
        wr('h00, 1);
        expect_out(1'b1, 3, 'h20, "R8 pending kept");
        wr('h40 + 3, 'h20);
        expect_out(1'b1, 33, 'h20, "R8 per-interrupt disable");
        do_ack(33);
        expect_out(1'b1, 34, 'h20, "R5 next in line");

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule